// File: doc/BRIEF.md
# Memory Channel Clear and Status Register Block

This block gives a host a window onto up to eight external memory channels through two 64-bit registers. One is a status word. It shows, for each channel, whether initialisation has finished, whether calibration failed, and whether a memory clear is still running. The other is a control or capability word, and its meaning depends on the `FEAT_REV` parameter.

With `FEAT_REV` = 0 the word is a control register. Its low byte takes clear requests, one bit per channel. Those bits are never stored. A 1 written to a bit fires a one-cycle start pulse toward that channel. The channel then shows busy until it returns a done strobe. The upper 56 bits of the word are plain read/write storage. Only the lower four channels can be present in this revision.

With any other revision the word is a capability register. It reports which of the eight channels are present, and the clear function is absent. The host polls the status word until the busy bit it started has dropped. Channel presence comes from a static strap input.

Top module: `memChanCsr`

## Requirements
- R1: A read of byte offset 0x08 returns init-done of channel n at bit n, calibration-fail of channel n at bit 8+n, and clear-busy of channel n at bit 16+n. All other bits read 0.
- R2: With revision 0, a read of offset 0x10 returns the presence strap of channels 0..3 in bits [3:0] and 0 in bits [7:4]. Bits [63:8] return the value last written there, or 0 after reset.
- R3: With a revision other than 0, a read of offset 0x10 returns the presence strap of channels 0..7 in bits [7:0] and 0 above. Writes to 0x10 change nothing and never start a clear.
- R4: With revision 0, a write to 0x10 that sets bit n, for a channel n that is present and idle, drives `chClrStart[n]` high for exactly one cycle. That cycle is the one after the write edge.
- R5: The busy bit of a started channel rises one cycle after its start pulse. It stays set until the clock edge that samples `chClrDone[n]` high, and is 0 from that edge on. A done strobe on an idle channel changes nothing.
- R6: A clear request to a channel that is not present is ignored. In revision 0 this includes every channel at index 4 or higher. No pulse fires and the busy bit stays 0.
- R7: A clear request to a channel that is busy, or whose start pulse is in flight, is ignored.
- R8: The clear-request bits [7:0] of offset 0x10 are not stored. Their read value is set by R2 or R3 alone.
- R9: Reads of any offset other than 0x08 and 0x10 return 0. Writes to those offsets change nothing.
- R10: After reset, all busy bits, start pulses and stored control bits are 0.
- R11: Read data appears on `regRdData` in the cycle after `regRdEn` is sampled high. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe |
| regAddr | input | ADDR_W | Byte offset of the access |
| regWrData | input | 64 | Write data |
| regRdData | output | 64 | Registered read data |
| chPresent | input | NUM_CH | Static strap, 1 for each fitted channel |
| chInitDone | input | NUM_CH | Per-channel initialisation finished |
| chCalFail | input | NUM_CH | Per-channel calibration failed |
| chClrDone | input | NUM_CH | Per-channel clear finished strobe |
| chClrStart | output | NUM_CH | Per-channel one-cycle clear start pulse |

## Verification
Two things can land on the same clock edge. A channel's done strobe can end its busy state while a new clear request arrives. That request may name the same channel, or another one. The bench raises done on channel 0 and, in the same cycle, writes a request naming channels 0 and 2. It then expects a start pulse only on channel 2, because channel 0 was still busy when the request was sampled. Two back-to-back status reads then show the busy set move from channel 0 alone, to empty, to channel 2 alone. A second instance at revision 1 receives the same bus traffic and must never pulse.

// File: rtl/memChanCsrPkg.sv
package memChanCsrPkg;
  // Strobes from the address decoder to the datapath
  typedef struct packed {
    logic wrCtrl;   // write to the control/capability word
    logic rdStat;   // read of the status word
    logic rdCtrl;   // read of the control/capability word
    logic rdZero;   // read of an undefined offset
  } csrStrobeT;
endpackage

// File: rtl/memChanCsrCtrl.sv
module memChanCsrCtrl
  import memChanCsrPkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int STAT_OFS = 8'h08,
  parameter int CTRL_OFS = 8'h10
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output csrStrobeT         strb
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFS);

  logic hitStat, hitCtrl;

  always_comb begin
    hitStat     = (regAddr == STAT_ADDR);
    hitCtrl     = (regAddr == CTRL_ADDR);
    strb.wrCtrl = regWrEn && hitCtrl;
    strb.rdStat = regRdEn && hitStat;
    strb.rdCtrl = regRdEn && hitCtrl;
    strb.rdZero = regRdEn && !hitStat && !hitCtrl;
  end
endmodule

// File: rtl/memChanCsrDatapath.sv
module memChanCsrDatapath
  import memChanCsrPkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int DATA_W   = 64,
  parameter int FEAT_REV = 0,
  parameter int V0_CH    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobeT         strb,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NUM_CH-1:0] chPresent,
  input  logic [NUM_CH-1:0] chInitDone,
  input  logic [NUM_CH-1:0] chCalFail,
  input  logic [NUM_CH-1:0] chClrDone,
  output logic [NUM_CH-1:0] chClrStart
);
  localparam int FIELD_W   = 8;
  localparam int CAL_LO    = FIELD_W;
  localparam int BUSY_LO   = 2 * FIELD_W;
  localparam int STORE_LO  = FIELD_W;
  localparam int PRESENT_W = (FEAT_REV == 0 && NUM_CH > V0_CH) ? V0_CH : NUM_CH;

  logic [NUM_CH-1:0] busyQ, pulseQ, reqMask, validMask;
  logic [DATA_W-1:0] statWord, ctrlWord, storeWord;

  // Presence qualified by the revision's bitmap width
  for (genvar n = 0; n < NUM_CH; n++) begin : gValid
    if (n < PRESENT_W) begin : gIn
      assign validMask[n] = chPresent[n];
    end else begin : gOut
      assign validMask[n] = 1'b0;
    end
  end

  if (FEAT_REV == 0) begin : gClear
    logic [DATA_W-1:STORE_LO] storeQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            storeQ <= '0;
      else if (strb.wrCtrl) storeQ <= regWrData[DATA_W-1:STORE_LO];
    end
    always_comb begin
      storeWord = '0;
      storeWord[DATA_W-1:STORE_LO] = storeQ;
      reqMask = strb.wrCtrl ? (regWrData[NUM_CH-1:0] & validMask & ~busyQ & ~pulseQ) : '0;
    end
  end else begin : gNoClear
    assign storeWord = '0;
    assign reqMask   = '0;
    always_ff @(posedge clk) begin
      if (rstN) assert_no_clear_rev_R3 : assert (pulseQ == '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseQ <= '0;
      busyQ  <= '0;
    end else begin
      pulseQ <= reqMask;
      busyQ  <= (busyQ & ~chClrDone) | pulseQ;
    end
  end

  assign chClrStart = pulseQ;

  always_comb begin
    statWord = '0;
    statWord[NUM_CH-1:0]         = chInitDone;
    statWord[CAL_LO +: NUM_CH]   = chCalFail;
    statWord[BUSY_LO +: NUM_CH]  = busyQ;
    ctrlWord = storeWord;
    ctrlWord[PRESENT_W-1:0] = chPresent[PRESENT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            regRdData <= '0;
    else if (strb.rdStat) regRdData <= statWord;
    else if (strb.rdCtrl) regRdData <= ctrlWord;
    else if (strb.rdZero) regRdData <= '0;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : gChk
    assert_pulse_single_R4 : assert property (@(posedge clk) disable iff (!rstN)
      pulseQ[n] |=> !pulseQ[n]);
    assert_busy_after_pulse_R5 : assert property (@(posedge clk) disable iff (!rstN)
      $rose(busyQ[n]) |-> $past(pulseQ[n]));
    assert_busy_clear_R5 : assert property (@(posedge clk) disable iff (!rstN)
      (busyQ[n] && chClrDone[n]) |=> !busyQ[n]);
    assert_absent_idle_R6 : assert property (@(posedge clk) disable iff (!rstN)
      !validMask[n] |-> (!busyQ[n] && !pulseQ[n]));
    assert_busy_no_restart_R7 : assert property (@(posedge clk) disable iff (!rstN)
      busyQ[n] |-> !pulseQ[n]);
  end
endmodule

// File: rtl/memChanCsr.sv
module memChanCsr
  import memChanCsrPkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int ADDR_W   = 8,
  parameter int FEAT_REV = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [63:0]       regWrData,
  output logic [63:0]       regRdData,
  input  logic [NUM_CH-1:0] chPresent,
  input  logic [NUM_CH-1:0] chInitDone,
  input  logic [NUM_CH-1:0] chCalFail,
  input  logic [NUM_CH-1:0] chClrDone,
  output logic [NUM_CH-1:0] chClrStart
);
  csrStrobeT strb;

  memChanCsrCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .strb(strb)
  );

  memChanCsrDatapath #(.NUM_CH(NUM_CH), .DATA_W(64), .FEAT_REV(FEAT_REV)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .regRdData(regRdData), .chPresent(chPresent), .chInitDone(chInitDone),
    .chCalFail(chCalFail), .chClrDone(chClrDone), .chClrStart(chClrStart)
  );
endmodule

// File: tb/memChanCsr_test.sv
module memChanCsr_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [63:0] regWrData = '0;
  logic [63:0] rdData0, rdData1;
  logic [7:0]  chPresent = 8'hF5, chInitDone = 8'hA5, chCalFail = 8'h3C, chClrDone = '0;
  logic [7:0]  clrStart0, clrStart1;
  int checks = 0, failures = 0;
  logic [63:0] got0, got1;

  always #4 clk = ~clk;

  memChanCsr #(.FEAT_REV(0)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdData0), .chPresent(chPresent),
    .chInitDone(chInitDone), .chCalFail(chCalFail), .chClrDone(chClrDone),
    .chClrStart(clrStart0));

  memChanCsr #(.FEAT_REV(1)) uutRev1 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdData1), .chPresent(chPresent),
    .chInitDone(chInitDone), .chCalFail(chCalFail), .chClrDone(chClrDone),
    .chClrStart(clrStart1));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    got0 = rdData0; got1 = rdData1;
  endtask

  // {isWrite, addr, data, expected read}
  localparam logic [136:0] VEC [10] = '{
    {1'b0, 8'h08, 64'h0, 64'h0000_0000_0000_3CA5},
    {1'b1, 8'h10, 64'hDEAD_BEEF_1234_5600, 64'h0},
    {1'b0, 8'h10, 64'h0, 64'hDEAD_BEEF_1234_5605},
    {1'b1, 8'h18, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
    {1'b0, 8'h18, 64'h0, 64'h0},
    {1'b0, 8'h00, 64'h0, 64'h0},
    {1'b0, 8'h10, 64'h0, 64'hDEAD_BEEF_1234_5605},
    {1'b1, 8'h10, 64'h0000_0000_0000_00FA, 64'h0},
    {1'b0, 8'h10, 64'h0, 64'h0000_0000_0000_0005},
    {1'b0, 8'h08, 64'h0, 64'h0000_0000_0000_3CA5}
  };

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 pulses", {56'h0, clrStart0}, 64'h0);
    rd(8'h10);
    chk("R10 store cleared", got0, 64'h5);
    rd(8'h08);
    chk("R10 busy cleared", got0, 64'h3CA5);

    // Vector table; ch1/ch3 absent, ch4..7 beyond rev0 map (R6)
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][136]) wr(VEC[i][135:128], VEC[i][127:64]);
      else begin
        rd(VEC[i][135:128]);
        chk("R1/R2/R8/R9 table read", got0, VEC[i][63:0]);
      end
      chk("R6 no pulse in table", {56'h0, clrStart0}, 64'h0);
    end
    rd(8'h10);
    chk("R3 rev1 capability", got1, 64'hF5);
    rd(8'h08);
    chk("R1 rev1 status", got1, 64'h3CA5);
    @(negedge clk);
    chk("R11 read data held", rdData0, 64'h3CA5);

    // R4/R5 start on channel 0
    wr(8'h10, 64'h1);
    chk("R4 pulse ch0", {56'h0, clrStart0}, 64'h1);
    chk("R3 rev1 no pulse", {56'h0, clrStart1}, 64'h0);
    rd(8'h08);
    chk("R4 pulse one cycle", {56'h0, clrStart0}, 64'h0);
    chk("R5 busy not yet", got0, 64'h3CA5);
    rd(8'h08);
    chk("R5 busy set", got0, 64'h0001_3CA5);
    repeat (5) @(negedge clk);
    // R7: request to busy channel ignored
    wr(8'h10, 64'h1);
    chk("R7 busy ch no pulse", {56'h0, clrStart0}, 64'h0);
    // R6: absent channel 1
    wr(8'h10, 64'h2);
    chk("R6 absent ch no pulse", {56'h0, clrStart0}, 64'h0);
    rd(8'h08);
    chk("R5 R6 busy only ch0", got0, 64'h0001_3CA5);
    // R5: done on idle channel 2 ignored
    chClrDone = 8'h04;
    @(negedge clk);
    chClrDone = 8'h00;
    rd(8'h08);
    chk("R5 idle done ignored", got0, 64'h0001_3CA5);

    // Same-cycle done on ch0 and request for ch0+ch2
    chClrDone = 8'h01;
    wr(8'h10, 64'h5);
    chClrDone = 8'h00;
    chk("R7 concurrent pulse only ch2", {56'h0, clrStart0}, 64'h4);
    rd(8'h08);
    chk("R5 concurrent busy gap", got0, 64'h3CA5);
    rd(8'h08);
    chk("R5 concurrent busy ch2", got0, 64'h0004_3CA5);
    chClrDone = 8'h04;
    @(negedge clk);
    chClrDone = 8'h00;
    rd(8'h08);
    chk("R5 ch2 cleared", got0, 64'h3CA5);

    // R3 writes to rev1 change nothing
    wr(8'h10, 64'hFFFF_0000_0000_0001);
    chk("R4 pulse ch0 again", {56'h0, clrStart0}, 64'h1);
    rd(8'h10);
    chk("R3 rev1 write ignored", got1, 64'hF5);
    chk("R2 R8 store kept, trigger not", got0, 64'hFFFF_0000_0000_0005);

    // R10 reset mid-clear
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(8'h08);
    chk("R10 busy reset", got0, 64'h3CA5);
    rd(8'h10);
    chk("R10 store reset", got0, 64'h5);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule